// File: doc/BRIEF.md
# Push-Button Song Playback Sequencer

This block plays back short stored melodies one note at a time. Three song-select buttons each start one of three tunes held in an on-chip table. Every table entry pairs a note code with a duration counted in timer ticks. At the default settings a tick is 10 ms of a 50 MHz clock. The sequencer presents each note code, with a valid flag, to the tone generator and to the key-highlight logic of the display. It holds the note for its programmed time, then stays silent for a short gap and fetches the next entry. An entry with zero duration ends the song, and the sequencer falls back to idle.

When no song is running, the live keyboard note code and its valid flag pass through to the outputs after one register stage. While a song runs, the live keyboard and all further button presses have no effect. The system reset button maps to the synchronous reset input. It aborts a song at any point.

Top module: `song_sequencer`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `note_code` is 0 and `note_valid` is 0, whatever the live key inputs are.
- R2: When idle, `note_code` and `note_valid` equal the `key_code` and `key_valid` values of the previous clock cycle.
- R3: A rising edge on `song_btn[s]` starts song s. Song s has 3+s notes, and entry i holds note code 1+8*s+floor(i/2) with a duration of 1+(i mod 3) ticks.
- R4: Each song note drives `note_valid`=1 with its code for exactly duration*TICK_DIV consecutive cycles.
- R5: Every song note, the last one included, is followed by exactly GAP_TICKS*TICK_DIV+2 cycles with `note_code`=0 and `note_valid`=0. After the last note's gap the block is idle again and passes the live key through.
- R6: Two consecutive identical notes (song 2, entries 0 and 1, both code 17) appear as two separate valid runs split by the silent gap.
- R7: During playback `key_code` and `key_valid` have no effect on the outputs.
- R8: Button rising edges during playback are ignored. A button still held when a song ends does not restart a song.
- R9: When several song buttons rise in the same cycle, the lowest-numbered one wins.
- R10: Asserting `rst` in the middle of a song aborts it. Afterwards the live key passes through and no song note reappears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (system reset button) |
| song_btn | input | SONGS | Raw song-select push buttons, bit s starts song s |
| key_code | input | NOTE_W | Live keyboard note code |
| key_valid | input | 1 | Live key is pressed |
| note_code | output | NOTE_W | Registered note code to tone generator and display |
| note_valid | output | 1 | Registered flag: a note is sounding |

## Verification
The bench builds the block with TICK_DIV=4 and GAP_TICKS=1. Each duration tick is then four cycles and each inter-note silence is six, so all three songs finish within a few hundred cycles. Every note length and gap length can then be measured to the exact cycle. The table shape stays at its defaults: three songs in slots of eight entries. This puts the repeated-note entry, the end markers and the lowest-index priority within reach of direct checks.

// File: rtl/song_seq_pkg.sv
`timescale 1ns/1ps
package song_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_CHECK,
    S_PLAY,
    S_GAP
  } seq_state_t;

  // Number of notes in song s (each slot also holds a zero-duration end marker)
  function automatic int song_len(input int s);
    return 3 + s;
  endfunction

  function automatic int entry_note(input int s, input int i);
    return 1 + 8 * s + i / 2;
  endfunction

  function automatic int entry_dur(input int s, input int i);
    return 1 + (i % 3);
  endfunction

endpackage

// File: rtl/btn_edge.sv
`timescale 1ns/1ps
module btn_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] rise
);

  logic [N-1:0] sync1, sync2, prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= raw;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  assign rise = sync2 & ~prev;

endmodule

// File: rtl/tick_gen.sv
`timescale 1ns/1ps
module tick_gen #(
  parameter int DIV = 500000
) (
  input  logic clk,
  input  logic clr,
  output logic tick
);

  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (clr || tick) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/song_rom.sv
`timescale 1ns/1ps
module song_rom
  import song_seq_pkg::*;
#(
  parameter int NOTE_W  = 6,
  parameter int DUR_W   = 4,
  parameter int SONGS   = 3,
  parameter int SLOT_AW = 3,
  parameter int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  output logic [NOTE_W-1:0] q_note,
  output logic [DUR_W-1:0]  q_dur
);

  localparam int SLOT   = 1 << SLOT_AW;
  localparam int DEPTH  = SONGS * SLOT;
  localparam int WORD_W = NOTE_W + DUR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] q;

  // Contents computed once; the array is only read, so it maps to block RAM
  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      if ((a % SLOT) < song_len(a / SLOT))
        mem[a] = {NOTE_W'(entry_note(a / SLOT, a % SLOT)),
                  DUR_W'(entry_dur(a / SLOT, a % SLOT))};
      else
        mem[a] = '0;
    end
  end

  always_ff @(posedge clk) q <= mem[addr];

  assign q_note = q[WORD_W-1:DUR_W];
  assign q_dur  = q[DUR_W-1:0];

endmodule

// File: rtl/song_sequencer.sv
`timescale 1ns/1ps
module song_sequencer
  import song_seq_pkg::*;
#(
  parameter int NOTE_W    = 6,
  parameter int DUR_W     = 4,
  parameter int SONGS     = 3,
  parameter int SLOT_AW   = 3,
  parameter int TICK_DIV  = 500000,
  parameter int GAP_TICKS = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SONGS-1:0]  song_btn,
  input  logic [NOTE_W-1:0] key_code,
  input  logic              key_valid,
  output logic [NOTE_W-1:0] note_code,
  output logic              note_valid
);

  localparam int SEL_W  = (SONGS > 1) ? $clog2(SONGS) : 1;
  localparam int ADDR_W = SEL_W + SLOT_AW;

  seq_state_t        state;
  logic [SONGS-1:0]  btn_rise;
  logic              tick, tick_clr;
  logic [ADDR_W-1:0] addr;
  logic [NOTE_W-1:0] rom_note, cur_note;
  logic [DUR_W-1:0]  rom_dur, remain;
  logic              start_hit;
  logic [SEL_W-1:0]  start_sel;

  btn_edge #(.N(SONGS)) i_btn (
    .clk (clk),
    .rst (rst),
    .raw (song_btn),
    .rise(btn_rise)
  );

  assign tick_clr = (state != S_PLAY) && (state != S_GAP);

  tick_gen #(.DIV(TICK_DIV)) i_tick (
    .clk (clk),
    .clr (tick_clr),
    .tick(tick)
  );

  song_rom #(
    .NOTE_W (NOTE_W),
    .DUR_W  (DUR_W),
    .SONGS  (SONGS),
    .SLOT_AW(SLOT_AW),
    .ADDR_W (ADDR_W)
  ) i_rom (
    .clk   (clk),
    .addr  (addr),
    .q_note(rom_note),
    .q_dur (rom_dur)
  );

  // Lowest-numbered button wins: scan downwards so the last hit kept is the lowest
  always_comb begin
    start_hit = 1'b0;
    start_sel = '0;
    for (int k = SONGS - 1; k >= 0; k--) begin
      if (btn_rise[k]) begin
        start_hit = 1'b1;
        start_sel = SEL_W'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      addr     <= '0;
      cur_note <= '0;
      remain   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start_hit) begin
            addr  <= {start_sel, SLOT_AW'(0)};
            state <= S_FETCH;
          end
        end
        S_FETCH: state <= S_CHECK;
        S_CHECK: begin
          if (rom_dur == '0) begin
            state <= S_IDLE;
          end else begin
            cur_note <= rom_note;
            remain   <= rom_dur;
            state    <= S_PLAY;
          end
        end
        S_PLAY: begin
          if (tick) begin
            if (remain == DUR_W'(1)) begin
              remain <= DUR_W'(GAP_TICKS);
              state  <= S_GAP;
            end else begin
              remain <= remain - 1'b1;
            end
          end
        end
        S_GAP: begin
          if (tick) begin
            if (remain == DUR_W'(1)) begin
              addr  <= addr + 1'b1;
              state <= S_FETCH;
            end else begin
              remain <= remain - 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      note_code  <= '0;
      note_valid <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          note_code  <= key_code;
          note_valid <= key_valid;
        end
        S_PLAY: begin
          note_code  <= cur_note;
          note_valid <= 1'b1;
        end
        default: begin
          note_code  <= '0;
          note_valid <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/song_seq_chk.sv
`timescale 1ns/1ps
module song_seq_chk
  import song_seq_pkg::*;
#(
  parameter int NOTE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input seq_state_t        state,
  input logic              tick,
  input logic [NOTE_W-1:0] cur_note,
  input logic [NOTE_W-1:0] key_code,
  input logic              key_valid,
  input logic [NOTE_W-1:0] note_code,
  input logic              note_valid
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!note_valid && note_code == '0));

  // R2
  idle_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |=> (note_code == $past(key_code) && note_valid == $past(key_valid)));

  // R4
  play_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_PLAY) |=> (note_valid && note_code == $past(cur_note)));

  // R4
  note_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_PLAY && !tick) |=> (state == S_PLAY && $stable(cur_note)));

  // R5
  gap_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_GAP || state == S_FETCH || state == S_CHECK) |=> (!note_valid && note_code == '0));

endmodule

bind song_sequencer song_seq_chk #(.NOTE_W(NOTE_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .state     (state),
  .tick      (tick),
  .cur_note  (cur_note),
  .key_code  (key_code),
  .key_valid (key_valid),
  .note_code (note_code),
  .note_valid(note_valid)
);

// File: tb/test_song_sequencer.sv
`timescale 1ns/1ps
module test_song_sequencer;

  localparam int NW     = 6;
  localparam int DW     = 4;
  localparam int NS     = 3;
  localparam int SA     = 3;
  localparam int DIV    = 4;
  localparam int GAP    = 1;
  localparam int SILENT = GAP * DIV + 2;
  localparam int KEY    = 63;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] song_btn = '0;
  logic [NW-1:0] key_code = '0;
  logic          key_valid = 1'b0;
  logic [NW-1:0] note_code;
  logic          note_valid;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  song_sequencer #(
    .NOTE_W(NW), .DUR_W(DW), .SONGS(NS), .SLOT_AW(SA),
    .TICK_DIV(DIV), .GAP_TICKS(GAP)
  ) i_song_sequencer (
    .clk(clk), .rst(rst), .song_btn(song_btn),
    .key_code(key_code), .key_valid(key_valid),
    .note_code(note_code), .note_valid(note_valid)
  );

  always #2.5 clk = ~clk;

  // Expected song contents, taken from R3
  function automatic int exp_len(input int s);        return 3 + s;             endfunction
  function automatic int exp_note(input int s, input int i); return 1 + 8*s + i/2; endfunction
  function automatic int exp_dur(input int s, input int i);  return 1 + (i % 3);   endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Measure a run of identical outputs starting at the current sample
  task automatic expect_run(input bit v, input int code, input int len,
                            input string req_code, input string req_len);
    int n = 0;
    chk(note_valid == v && note_code == NW'(code), req_code, int'(note_code), code);
    while (note_valid == v && note_code == NW'(code) && n < len + 8) begin
      n++;
      @(negedge clk);
    end
    chk(n == len, req_len, n, len);
  endtask

  task automatic wait_first_note(output bit ok);
    int n = 0;
    while (!(note_valid && note_code != NW'(KEY)) && n < 60) begin
      n++;
      @(negedge clk);
    end
    ok = (n < 60);
  endtask

  task automatic hold_key_check(input int cycles, input string req);
    int bad = 0;
    repeat (cycles) begin
      if (!(note_valid && note_code == NW'(KEY))) bad++;
      @(negedge clk);
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    key_code = NW'(KEY);
    key_valid = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset overrides the live key
    chk(!note_valid && note_code == '0, "R1", int'(note_code), 0);
    rst = 1'b0;
    key_valid = 1'b0;
    key_code = '0;
    @(negedge clk);
  endtask

  task automatic t_pass;
    int codes[4] = '{5, 40, 0, 63};
    bit vals[4]  = '{1'b1, 1'b0, 1'b1, 1'b1};
    for (int k = 0; k < 4; k++) begin
      key_code  = NW'(codes[k]);
      key_valid = vals[k];
      @(negedge clk);
      // R2: one register stage from key to output
      chk(note_code == NW'(codes[k]) && note_valid == vals[k], "R2",
          int'(note_code), codes[k]);
    end
  endtask

  task automatic t_song(input int s, input bit disturb);
    bit ok;
    key_code  = NW'(KEY);
    key_valid = 1'b1;
    @(negedge clk);
    song_btn[s] = 1'b1;
    wait_first_note(ok);
    chk(ok, "R3", int'(ok), 1);
    // R8: other buttons rise during playback; R7: key stays valid throughout
    if (disturb) song_btn = '1;
    else         song_btn = '0;
    for (int i = 0; i < exp_len(s); i++) begin
      expect_run(1'b1, exp_note(s, i), exp_dur(s, i) * DIV, "R3", "R4");
      expect_run(1'b0, 0, SILENT, "R7", (s == 2 && i == 0) ? "R6" : "R5");
    end
    // R5: back to idle with pass-through; R8: held buttons do not restart
    hold_key_check(30, disturb ? "R8" : "R5");
    song_btn = '0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_simul_abort;
    bit ok;
    key_code  = NW'(KEY);
    key_valid = 1'b1;
    @(negedge clk);
    song_btn = 3'b110;
    wait_first_note(ok);
    // R9: buttons 1 and 2 together start song 1
    chk(ok && note_code == NW'(exp_note(1, 0)), "R9", int'(note_code), exp_note(1, 0));
    repeat (3) @(negedge clk);
    rst = 1'b1;
    song_btn = '0;
    @(negedge clk);
    chk(!note_valid && note_code == '0, "R1", int'(note_code), 0);
    rst = 1'b0;
    @(negedge clk);
    // R10: aborted song never resumes
    hold_key_check(40, "R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_pass();
    t_song(0, 1'b0);
    t_song(1, 1'b1);
    t_song(2, 1'b0);
    t_simul_abort();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule